// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switching Fabric

This block moves up to N packets per clock from N input ports to N output ports through a multistage network of 2x2 switching elements. The fabric has log2 N columns. Ahead of each column the lines are rewired by a perfect shuffle, in which line i moves to the position found by rotating the bits of i one place to the left. Each element then steers every packet it holds from one bit of that packet's destination tag. The first column uses the most significant bit and the last column uses bit 0. A 0 sends the packet to the element's upper output, even line, and a 1 sends it to the lower output, odd line. After the last column the line index equals the destination.

The network can block. When two live packets at one element ask for the same output, the packet on the upper input moves on. The packet on the lower input is discarded and its source is marked blocked. A discarded packet takes no part in any later column. The results of all columns are captured in one register stage at the fabric edge. Each output then shows a valid bit, the payload and the index of the input it came from. Each input shows whether its packet was delivered or blocked. Both sets of results appear one clock after the request.

Top module: `omega_fabric`

## Requirements
- R1: With N = 16 (4 columns), a lone valid packet from any input reaches the output whose index equals its 4-bit destination, whatever that destination is.
- R2: A delivered packet appears at the output equal to its destination, with its payload unchanged and the output's source field equal to the index of the input that sent it.
- R3: When two live packets contend for one element output, the one on the element's upper (even) input is delivered and the one on the lower (odd) input is reported blocked. Example: inputs 0 and 8 both addressed to 5 give output 5 with source 0, and input 8 blocked.
- R4: A packet discarded in an earlier column does not contend later. Example: input 0 to 0, input 8 to 7 and input 4 to 5 deliver inputs 0 and 4 and block input 8.
- R5: No two delivered packets share an output, and the number of valid outputs equals the number of delivered inputs.
- R6: The results for a request set appear exactly one clock after the edge that samples it, and they hold until the next edge.
- R7: While reset (rst_n low) is sampled at an edge, every output valid bit and every input delivered/blocked bit is cleared at that edge.
- R8: For each input, delivered and blocked are never both 1. Exactly one of them is 1 when that input was valid in the sampled cycle, and neither is 1 when it was not.
- R9: With N = 16, the identity permutation delivers all 16 packets. The bit-reversal permutation delivers exactly 4 packets, those from inputs 0 to 3, and blocks the other 12.
- R10: Inputs whose valid bit is 0 produce no valid output and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NPORTS | Per-input packet present |
| req_dest | input | NPORTS*ADDR_W | Per-input destination index, input i in bits [i*ADDR_W +: ADDR_W] |
| req_data | input | NPORTS*DATA_W | Per-input payload, input i in bits [i*DATA_W +: DATA_W] |
| dlv_valid | output | NPORTS | Per-output packet delivered |
| dlv_data | output | NPORTS*DATA_W | Per-output payload |
| dlv_src | output | NPORTS*ADDR_W | Per-output index of the input that reached it |
| acc_ok | output | NPORTS | Per-input: packet delivered |
| acc_drop | output | NPORTS | Per-input: packet blocked inside the fabric |

## Verification
Every result of this block is due one clock after its request. The bench drives a request set on a falling edge, which the next rising edge captures. It then reads all outputs and statuses on the falling edge that follows, a full half period away from any edge. The latency scenario also reads the outputs just after a new request is driven, before the capturing edge, and requires the previous results to still be present. Expected values come from a path model in the bench. That model places each packet after column k at the window of the concatenated source and destination bits, and it settles conflicts by the parity of each packet's input line.

// File: rtl/omega_pkg.sv
// Package: shared helpers for the shuffle-exchange fabric.
// Assumes the port count is a power of two, with addr_w = log2 of it.
package omega_pkg;

    // Position a line takes after a perfect shuffle: rotate left by one.
    function automatic int unsigned shuffle_pos(int unsigned idx, int unsigned addr_w);
        int unsigned mask;
        mask = (32'd1 << addr_w) - 1;
        return ((idx << 1) | (idx >> (addr_w - 1))) & mask;
    endfunction

    // Width of one line bundle: valid, destination, source, payload.
    function automatic int unsigned line_width(int unsigned addr_w, int unsigned data_w);
        return 1 + 2 * addr_w + data_w;
    endfunction

endpackage

// File: rtl/omega_shuffle.sv
// Module: omega_shuffle
// Pure wiring that applies the perfect-shuffle permutation to a column of
// lines: input line i drives output position rotl(i). No logic, no state.
// Assumes NPORTS is a power of two.
module omega_shuffle #(
    parameter int NPORTS = 16,
    parameter int LINE_W = 17
) (
    input  logic [LINE_W-1:0] lin  [NPORTS],
    output logic [LINE_W-1:0] lout [NPORTS]
);
    localparam int ADDR_W = $clog2(NPORTS);

    // One wire per line, placed at its shuffled position.
    for (genvar i = 0; i < NPORTS; i++) begin : g_wire
        localparam int DST = omega_pkg::shuffle_pos(i, ADDR_W);
        assign lout[DST] = lin[i];
    end
endmodule

// File: rtl/omega_elem.sv
// Module: omega_elem
// One 2x2 switching element. Each live packet goes to the upper output when
// its destination bit for this column is 0 and to the lower output when it
// is 1. On a clash the upper input keeps its way and the lower input packet
// is discarded with drop_lo raised. Unused outputs carry an all-zero
// (invalid) line. Assumes line layout {valid, dest, src, data}.
module omega_elem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int STAGE  = 0
) (
    input  logic [2*ADDR_W+DATA_W:0] in_up,
    input  logic [2*ADDR_W+DATA_W:0] in_lo,
    output logic [2*ADDR_W+DATA_W:0] out_up,
    output logic [2*ADDR_W+DATA_W:0] out_lo,
    output logic                     drop_lo
);
    localparam int VLD_BIT  = DATA_W + 2 * ADDR_W;
    localparam int DEST_LSB = DATA_W + ADDR_W;
    localparam int SEL_BIT  = DEST_LSB + ADDR_W - 1 - STAGE;

    logic up_v, lo_v, up_sel, lo_sel;

    assign up_v   = in_up[VLD_BIT];
    assign lo_v   = in_lo[VLD_BIT];
    assign up_sel = in_up[SEL_BIT];
    assign lo_sel = in_lo[SEL_BIT];

    // Steer both packets, giving the upper input priority on a clash.
    always_comb begin
        out_up  = '0;
        out_lo  = '0;
        drop_lo = 1'b0;
        if (up_v) begin
            if (up_sel) out_lo = in_up;
            else        out_up = in_up;
        end
        if (lo_v) begin
            if (up_v && (up_sel == lo_sel)) drop_lo = 1'b1;
            else if (lo_sel)                out_lo  = in_lo;
            else                            out_up  = in_lo;
        end
    end
endmodule

// File: rtl/omega_stage.sv
// Module: omega_stage
// One column of the fabric: a perfect shuffle followed by NPORTS/2 elements.
// Reports a per-source mask of packets discarded in this column.
// Assumes NPORTS is a power of two and lines carry their source index.
module omega_stage #(
    parameter int NPORTS = 16,
    parameter int DATA_W = 8,
    parameter int STAGE  = 0
) (
    input  logic [2*$clog2(NPORTS)+DATA_W:0] lin  [NPORTS],
    output logic [2*$clog2(NPORTS)+DATA_W:0] lout [NPORTS],
    output logic [NPORTS-1:0]                drop_src
);
    localparam int ADDR_W  = $clog2(NPORTS);
    localparam int LINE_W  = omega_pkg::line_width(ADDR_W, DATA_W);
    localparam int HALF    = NPORTS / 2;
    localparam int SRC_LSB = DATA_W;

    logic [LINE_W-1:0] shuf [NPORTS];
    logic [HALF-1:0]   drop;

    omega_shuffle #(.NPORTS(NPORTS), .LINE_W(LINE_W)) u_shuf (
        .lin  (lin),
        .lout (shuf)
    );

    for (genvar j = 0; j < HALF; j++) begin : g_elem
        omega_elem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGE(STAGE)) u_elem (
            .in_up   (shuf[2*j]),
            .in_lo   (shuf[2*j+1]),
            .out_up  (lout[2*j]),
            .out_lo  (lout[2*j+1]),
            .drop_lo (drop[j])
        );
    end

    // Map each element's discard to the source index of the lost packet.
    always_comb begin
        drop_src = '0;
        for (int j = 0; j < HALF; j++) begin
            if (drop[j]) drop_src[shuf[2*j+1][SRC_LSB +: ADDR_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/omega_fabric.sv
// Module: omega_fabric (top)
// Self-routing shuffle-exchange fabric: log2(NPORTS) columns of 2x2
// elements, results registered once at the edge (latency one clock).
// Assumes NPORTS is a power of two, at least 2. Reset is synchronous,
// active low, and clears valid and status bits only.
module omega_fabric #(
    parameter int NPORTS = 16,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NPORTS-1:0]                 req_valid,
    input  logic [NPORTS*$clog2(NPORTS)-1:0]  req_dest,
    input  logic [NPORTS*DATA_W-1:0]          req_data,
    output logic [NPORTS-1:0]                 dlv_valid,
    output logic [NPORTS*DATA_W-1:0]          dlv_data,
    output logic [NPORTS*$clog2(NPORTS)-1:0]  dlv_src,
    output logic [NPORTS-1:0]                 acc_ok,
    output logic [NPORTS-1:0]                 acc_drop
);
    localparam int ADDR_W   = $clog2(NPORTS);
    localparam int LINE_W   = omega_pkg::line_width(ADDR_W, DATA_W);
    localparam int VLD_BIT  = DATA_W + 2 * ADDR_W;
    localparam int DEST_LSB = DATA_W + ADDR_W;
    localparam int SRC_LSB  = DATA_W;

    logic [LINE_W-1:0] lines [ADDR_W+1][NPORTS];
    logic [NPORTS-1:0] drops [ADDR_W];
    logic [NPORTS-1:0] vmask [ADDR_W+1];
    logic [NPORTS-1:0] blocked;

    // Bundle each request with its own source index.
    for (genvar i = 0; i < NPORTS; i++) begin : g_pack
        assign lines[0][i] = {req_valid[i], req_dest[i*ADDR_W +: ADDR_W],
                              ADDR_W'(i), req_data[i*DATA_W +: DATA_W]};
    end

    for (genvar k = 0; k < ADDR_W; k++) begin : g_stage
        omega_stage #(.NPORTS(NPORTS), .DATA_W(DATA_W), .STAGE(k)) u_stage (
            .lin      (lines[k]),
            .lout     (lines[k+1]),
            .drop_src (drops[k])
        );
    end

    for (genvar k = 0; k <= ADDR_W; k++) begin : g_vmask
        for (genvar p = 0; p < NPORTS; p++) begin : g_bit
            assign vmask[k][p] = lines[k][p][VLD_BIT];
        end
    end

    // Merge the per-column discards into one per-source blocked mask.
    always_comb begin
        blocked = '0;
        for (int k = 0; k < ADDR_W; k++) blocked = blocked | drops[k];
    end

    // Capture valid bits and statuses; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid <= '0;
            acc_ok    <= '0;
            acc_drop  <= '0;
        end else begin
            dlv_valid <= vmask[ADDR_W];
            acc_ok    <= req_valid & ~blocked;
            acc_drop  <= req_valid & blocked;
        end
    end

    // Capture payload and source fields of the final column.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            dlv_data[p*DATA_W +: DATA_W] <= lines[ADDR_W][p][DATA_W-1:0];
            dlv_src[p*ADDR_W +: ADDR_W]  <= lines[ADDR_W][p][SRC_LSB +: ADDR_W];
        end
    end

    // Column checks: steering bit matches the line parity; packets are conserved.
    for (genvar k = 0; k < ADDR_W; k++) begin : g_chk
        p_conserve_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(vmask[k]) == $countones(vmask[k+1]) + $countones(drops[k]));
        for (genvar p = 0; p < NPORTS; p++) begin : g_line
            p_route_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
                lines[k+1][p][VLD_BIT] |->
                (lines[k+1][p][DEST_LSB + ADDR_W - 1 - k] == 1'(p % 2)));
        end
    end

    p_cnt_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dlv_valid) == $countones(acc_ok));

    p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok & acc_drop) == '0);

    p_status_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((acc_ok | acc_drop) == $past(req_valid)));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (dlv_valid == '0 && acc_ok == '0 && acc_drop == '0));
endmodule

// File: tb/tb_omega_fabric.sv
`timescale 1ns/1ps
module tb_omega_fabric;
    localparam int N  = 16;
    localparam int LG = 4;
    localparam int W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*LG-1:0] req_dest  = '0;
    logic [N*W-1:0]  req_data  = '0;
    logic [N-1:0]    dlv_valid;
    logic [N*W-1:0]  dlv_data;
    logic [N*LG-1:0] dlv_src;
    logic [N-1:0]    acc_ok;
    logic [N-1:0]    acc_drop;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_v [N];
    int m_d [N];
    int m_p [N];
    int e_ok [N];
    int e_src [N];
    int e_v [N];

    always #2.5 clk = ~clk;

    omega_fabric #(.NPORTS(N), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_data(req_data), .dlv_valid(dlv_valid), .dlv_data(dlv_data),
        .dlv_src(dlv_src), .acc_ok(acc_ok), .acc_drop(acc_drop)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Path model: after column k a packet sits at the low LG bits of {src,dest} >> (LG-1-k).
    task automatic model();
        int alive [N];
        int pos [N];
        int odd [N];
        int kill [N];
        for (int s = 0; s < N; s++) alive[s] = m_v[s];
        for (int k = 0; k < LG; k++) begin
            for (int s = 0; s < N; s++) begin
                int prev;
                int inp;
                prev = (k == 0) ? s : (((s << k) | (m_d[s] >> (LG - k))) & (N - 1));
                inp = ((prev << 1) | (prev >> (LG - 1))) & (N - 1);
                odd[s] = inp & 1;
                pos[s] = ((s << (k + 1)) | (m_d[s] >> (LG - 1 - k))) & (N - 1);
                kill[s] = 0;
            end
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++)
                    if (a != b && alive[a] != 0 && alive[b] != 0 && pos[a] == pos[b]
                        && odd[a] == 0 && odd[b] == 1) kill[b] = 1;
            for (int s = 0; s < N; s++) if (kill[s] != 0) alive[s] = 0;
        end
        for (int p = 0; p < N; p++) begin e_v[p] = 0; e_src[p] = 0; end
        for (int s = 0; s < N; s++) begin
            e_ok[s] = alive[s];
            if (alive[s] != 0) begin e_v[m_d[s]] = 1; e_src[m_d[s]] = s; end
        end
    endtask

    // Drive the model arrays on a falling edge; results are due one edge later.
    task automatic drive();
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            req_valid[i]            = (m_v[i] != 0);
            req_dest[i*LG +: LG]    = LG'(m_d[i]);
            req_data[i*W +: W]      = W'(m_p[i]);
        end
    endtask

    // Compare every output and status against the model at the falling edge after capture.
    task automatic compare(string req);
        int nout;
        int nok;
        model();
        @(negedge clk);
        nout = 0; nok = 0;
        for (int p = 0; p < N; p++) begin
            chk(req, $sformatf("out%0d valid", p), int'(dlv_valid[p]), e_v[p]);
            if (e_v[p] != 0 && dlv_valid[p]) begin
                chk(req, $sformatf("out%0d src", p), int'(dlv_src[p*LG +: LG]), e_src[p]);
                chk(req, $sformatf("out%0d data", p), int'(dlv_data[p*W +: W]),
                    m_p[e_src[p]] & 8'hff);
            end
            nout += int'(dlv_valid[p]);
        end
        for (int i = 0; i < N; i++) begin
            chk(req, $sformatf("in%0d ok", i), int'(acc_ok[i]), e_ok[i]);
            chk(req, $sformatf("in%0d drop", i), int'(acc_drop[i]),
                (m_v[i] != 0 && e_ok[i] == 0) ? 1 : 0);
            nok += int'(acc_ok[i]);
        end
        chk("R5", "outputs vs delivered count", nout, nok);
    endtask

    task automatic clear_req(int seed);
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_p[i] = (i * 17 + seed) & 8'hff;
        end
    endtask

    task automatic t_reset();
        clear_req(3);
        for (int i = 0; i < N; i++) begin m_v[i] = 1; m_d[i] = i; end
        drive();
        @(negedge clk);
        chk("R7", "valid in reset", int'(dlv_valid), 0);
        chk("R7", "ok in reset", int'(acc_ok), 0);
        chk("R7", "drop in reset", int'(acc_drop), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        for (int d = 0; d < N; d++) begin
            clear_req(d);
            m_v[(d * 5 + 3) % N] = 1;
            m_d[(d * 5 + 3) % N] = d;
            drive();
            compare("R1");
            chk("R1", $sformatf("lone packet to %0d", d), int'(dlv_valid[d]), 1);
        end
    endtask

    task automatic t_identity();
        clear_req(40);
        for (int i = 0; i < N; i++) begin m_v[i] = 1; m_d[i] = i; end
        drive();
        compare("R2");
        chk("R9", "identity delivered", $countones(acc_ok), 16);
    endtask

    task automatic t_bitrev();
        clear_req(77);
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1;
            m_d[i] = ((i & 1) << 3) | ((i & 2) << 1) | ((i & 4) >> 1) | ((i & 8) >> 3);
        end
        drive();
        compare("R9");
        chk("R9", "bitrev delivered mask", int'(acc_ok), 16'h000f);
        chk("R9", "bitrev blocked count", $countones(acc_drop), 12);
    endtask

    task automatic t_upper_wins();
        clear_req(9);
        m_v[0] = 1; m_d[0] = 5;
        m_v[8] = 1; m_d[8] = 5;
        drive();
        compare("R3");
        chk("R3", "out5 source", int'(dlv_src[5*LG +: LG]), 0);
        chk("R3", "in8 blocked", int'(acc_drop[8]), 1);
    endtask

    task automatic t_dropped_no_part();
        clear_req(21);
        m_v[0] = 1; m_d[0] = 0;
        m_v[8] = 1; m_d[8] = 7;
        m_v[4] = 1; m_d[4] = 5;
        drive();
        compare("R4");
        chk("R4", "in4 delivered", int'(acc_ok[4]), 1);
        chk("R4", "out5 source", int'(dlv_src[5*LG +: LG]), 4);
        chk("R4", "in8 blocked", int'(acc_drop[8]), 1);
    endtask

    task automatic t_idle();
        clear_req(5);
        for (int i = 0; i < N; i++) m_d[i] = i;
        drive();
        compare("R10");
        chk("R10", "no outputs when idle", int'(dlv_valid), 0);
        chk("R8", "no status when idle", int'(acc_ok | acc_drop), 0);
    endtask

    task automatic t_latency();
        clear_req(50);
        for (int i = 0; i < N; i++) begin m_v[i] = 1; m_d[i] = i; end
        drive();
        compare("R6");
        clear_req(51);
        m_v[2] = 1; m_d[2] = 9;
        drive();
        #1;
        chk("R6", "old results held before edge", int'(dlv_valid), 16'hffff);
        compare("R6");
        chk("R6", "new result after one edge", int'(dlv_valid), 16'h0200);
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hace1;
        for (int n = 0; n < 40; n++) begin
            clear_req(n * 3);
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                m_v[i] = (lfsr[3:0] != 4'd0) ? 1 : 0;
                m_d[i] = int'(lfsr[9:6]);
            end
            drive();
            compare("R8");
        end
    endtask

    initial begin
        t_reset();
        t_single();
        t_identity();
        t_bitrev();
        t_upper_wins();
        t_dropped_no_part();
        t_idle();
        t_latency();
        t_random();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule